// File: doc/BRIEF.md
# Instruction Reuse Classifier

This block keeps one small signed confidence counter per load/store instruction, selected by the low bits of the instruction's program counter. Every access presents its PC together with the outcome of the data-cache lookup and the outcome of a zone-map lookup. The block classifies the instruction as bypass, useless, normal, useful or reuse, and then adjusts the counter from the lookup outcomes. The surrounding cache uses the class to choose where, or whether, the incoming line is inserted.

The classification is read combinationally from the entry's stored value in the same cycle as the access. The stored value changes at the next rising clock edge. The update is asymmetric. A counter that is confidently on one side moves back by a large step when an access contradicts it, and by a single unit otherwise. Only two outcome combinations change the counter: a cache hit, and a cache miss that also misses the zone map.

Top module: `pc_reuse_classifier`

## Requirements
- R1: The table has 512 entries, selected by PC bits [8:0]. Higher PC bits have no effect, so two PCs that agree in bits [8:0] share one entry.
- R2: The class code is 3 bits and follows the stored value v. It is 0 (bypass) for v < -96, 1 (useless) for -96 <= v < -64, 2 (normal) for -64 <= v <= 64, 3 (useful) for 64 < v <= 96, and 4 (reuse) for v > 96.
- R3: The class output reflects the entry selected by the present PC as stored before this access's update, in the same cycle the PC is presented, whether or not the access strobe is high.
- R4: On a strobed access with a cache hit, the counter rises by 8 if the class is bypass or useless, and by 1 otherwise. The zone-map flag is then irrelevant.
- R5: On a strobed access that misses both the cache and the zone map, the counter falls by 8 if the class is useful or reuse, and by 1 otherwise.
- R6: A cache miss with a zone-map hit leaves the counter unchanged. Any cycle without the access strobe also leaves it unchanged.
- R7: Counters are 8-bit two's complement and saturate at +127 and -128. They never wrap.
- R8: After reset every entry holds 0, which is class 2 (normal).
- R9: An access to an entry updated in the previous cycle sees the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld_i | input | 1 | Access strobe; enables the counter update |
| acc_pc_i | input | 32 | Program counter of the issuing instruction |
| cache_hit_i | input | 1 | 1 when the cache lookup hit |
| map_hit_i | input | 1 | 1 when the zone-map lookup found the location already touched |
| reuse_class_o | output | 3 | Class of the selected entry before this access's update |

## Verification
Two functions share one cycle on every strobed access: reading and classifying an entry, and writing that same entry's next value. The step size is chosen from the class that is being output in that cycle. The bench holds one PC across long runs of consecutive accesses, so each cycle reads an entry written at the previous edge. It also drives the counter through every class threshold and into both saturation limits. A behavioural model compares the class output in every cycle, and any step of the wrong size or any mis-timed write shows up as a class mismatch at the next threshold crossing.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [2:0] {
    RC_BYPASS  = 3'd0,
    RC_USELESS = 3'd1,
    RC_NORMAL  = 3'd2,
    RC_USEFUL  = 3'd3,
    RC_REUSE   = 3'd4
  } rc_class_e;
endpackage

// File: rtl/rc_class_decode.sv
module rc_class_decode
  import rc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LO_HARD = -96,
  parameter int LO_SOFT = -64,
  parameter int HI_SOFT = 64,
  parameter int HI_HARD = 96
) (
  input  logic signed [CNT_W-1:0] val_i,
  output rc_class_e               cls_o
);
  always_comb begin
    if (int'(val_i) < LO_HARD)      cls_o = RC_BYPASS;
    else if (int'(val_i) < LO_SOFT) cls_o = RC_USELESS;
    else if (int'(val_i) > HI_HARD) cls_o = RC_REUSE;
    else if (int'(val_i) > HI_SOFT) cls_o = RC_USEFUL;
    else                            cls_o = RC_NORMAL;
  end
endmodule

// File: rtl/rc_step_calc.sv
module rc_step_calc
  import rc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int BIG_STEP = 8
) (
  input  logic                    acc_vld_i,
  input  logic                    cache_hit_i,
  input  logic                    map_hit_i,
  input  logic signed [CNT_W-1:0] val_i,
  input  rc_class_e               cls_i,
  output logic                    wr_en_o,
  output logic signed [CNT_W-1:0] wr_val_o
);
  localparam int SW = CNT_W + 2;
  localparam logic signed [SW-1:0] MAX_V = SW'((2 ** (CNT_W - 1)) - 1);
  localparam logic signed [SW-1:0] MIN_V = -SW'(2 ** (CNT_W - 1));
  localparam logic signed [SW-1:0] BIG   = SW'(BIG_STEP);
  localparam logic signed [SW-1:0] ONE   = SW'(1);

  logic              do_inc;
  logic              do_dec;
  logic signed [SW-1:0] delta;
  logic signed [SW-1:0] sum;

  assign do_inc  = acc_vld_i && cache_hit_i;
  assign do_dec  = acc_vld_i && !cache_hit_i && !map_hit_i;
  assign wr_en_o = do_inc || do_dec;

  always_comb begin
    delta = '0;
    if (do_inc) begin
      delta = (cls_i == RC_BYPASS || cls_i == RC_USELESS) ? BIG : ONE;
    end else if (do_dec) begin
      delta = (cls_i == RC_USEFUL || cls_i == RC_REUSE) ? -BIG : -ONE;
    end
    sum = SW'(val_i) + delta;
    if (sum > MAX_V)      wr_val_o = MAX_V[CNT_W-1:0];
    else if (sum < MIN_V) wr_val_o = MIN_V[CNT_W-1:0];
    else                  wr_val_o = sum[CNT_W-1:0];
  end
endmodule

// File: rtl/rc_counter_table.sv
module rc_counter_table #(
  parameter int IDX_W = 9,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic                    wr_en_i,
  input  logic signed [CNT_W-1:0] wr_val_i,
  output logic signed [CNT_W-1:0] rd_val_o
);
  localparam int DEPTH = 2 ** IDX_W;

  logic signed [CNT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[idx_i] <= wr_val_i;
    end
  end

  assign rd_val_o = mem[idx_i];
endmodule

// File: rtl/pc_reuse_classifier.sv
module pc_reuse_classifier
  import rc_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 9,
  parameter int CNT_W    = 8,
  parameter int BIG_STEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_vld_i,
  input  logic [PC_W-1:0] acc_pc_i,
  input  logic            cache_hit_i,
  input  logic            map_hit_i,
  output logic [2:0]      reuse_class_o
);
  localparam int MAX_I = (2 ** (CNT_W - 1)) - 1;
  localparam int MIN_I = -(2 ** (CNT_W - 1));

  logic [1:0]              rst_sync;
  logic                    rst_int_n;
  logic [IDX_W-1:0]        tbl_idx;
  logic signed [CNT_W-1:0] rd_val;
  logic signed [CNT_W-1:0] wr_val;
  logic                    wr_en;
  rc_class_e               cur_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign tbl_idx = acc_pc_i[IDX_W-1:0];

  generate
    if (PC_W > IDX_W) begin : g_hi
      logic pc_hi_unused;
      assign pc_hi_unused = ^acc_pc_i[PC_W-1:IDX_W];
    end
  endgenerate

  rc_counter_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .idx_i    (tbl_idx),
    .wr_en_i  (wr_en),
    .wr_val_i (wr_val),
    .rd_val_o (rd_val)
  );

  rc_class_decode #(.CNT_W(CNT_W)) u_dec (
    .val_i (rd_val),
    .cls_o (cur_cls)
  );

  rc_step_calc #(.CNT_W(CNT_W), .BIG_STEP(BIG_STEP)) u_step (
    .acc_vld_i   (acc_vld_i),
    .cache_hit_i (cache_hit_i),
    .map_hit_i   (map_hit_i),
    .val_i       (rd_val),
    .cls_i       (cur_cls),
    .wr_en_o     (wr_en),
    .wr_val_o    (wr_val)
  );

  assign reuse_class_o = cur_cls;

  // R4: a hit never lowers the counter and raises it unless saturated
  a_r4_hit_raises: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_vld_i && cache_hit_i) |-> (wr_val > rd_val) || (int'(rd_val) == MAX_I));

  // R5: a double miss lowers the counter unless saturated
  a_r5_miss_lowers: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_vld_i && !cache_hit_i && !map_hit_i) |-> (wr_val < rd_val) || (int'(rd_val) == MIN_I));

  // R6: a map hit on a cache miss writes nothing
  a_r6_map_hit_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_vld_i && !cache_hit_i && map_hit_i) |-> !wr_en);

  // R7: any write moves the counter by at most the big step
  a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |-> ((int'(wr_val) - int'(rd_val)) <= BIG_STEP) && ((int'(rd_val) - int'(wr_val)) <= BIG_STEP));

  // R9: the entry written last cycle reads back the written value
  a_r9_read_after_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(wr_en) && (tbl_idx == $past(tbl_idx))) |-> (rd_val == $past(wr_val)));
endmodule

// File: tb/sim_pc_reuse_classifier.sv
module sim_pc_reuse_classifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_vld;
  logic [31:0] acc_pc;
  logic        cache_hit;
  logic        map_hit;
  logic [2:0]  reuse_class;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int model [512];

  always #5 clk = ~clk;

  pc_reuse_classifier u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_vld_i     (acc_vld),
    .acc_pc_i      (acc_pc),
    .cache_hit_i   (cache_hit),
    .map_hit_i     (map_hit),
    .reuse_class_o (reuse_class)
  );

  function automatic int m_cls(int v);
    if (v < -96) return 0;
    if (v < -64) return 1;
    if (v > 96)  return 4;
    if (v > 64)  return 3;
    return 2;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s class actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare before the rising edge, advance model
  task automatic cyc(string tag, logic vld, logic [31:0] pc, logic ch, logic mh);
    int i;
    int c;
    @(negedge clk);
    acc_vld = vld; acc_pc = pc; cache_hit = ch; map_hit = mh;
    #3;
    i = int'(pc[8:0]);
    c = m_cls(model[i]);
    chk(tag, int'(reuse_class), c);
    if (vld) begin
      if (ch)       model[i] += (c <= 1) ? 8 : 1;
      else if (!mh) model[i] -= (c >= 3) ? 8 : 1;
      if (model[i] > 127)  model[i] = 127;
      if (model[i] < -128) model[i] = -128;
    end
  endtask

  task automatic expect_lit(string tag, logic [31:0] pc, int exp);
    @(negedge clk);
    acc_vld = 1'b0; acc_pc = pc; cache_hit = 1'b0; map_hit = 1'b0;
    #3;
    chk(tag, int'(reuse_class), exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 0;
    rst_n = 1'b0; acc_vld = 1'b0; acc_pc = '0; cache_hit = 1'b0; map_hit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset state is normal everywhere sampled
    for (int k = 0; k < 8; k++) cyc("R8", 1'b0, 32'(k * 67), 1'b0, 1'b0);

    // R2: exact threshold 64 vs 65 on a fresh entry
    for (int k = 0; k < 64; k++) cyc("R4", 1'b1, 32'h7, 1'b1, 1'b0);
    expect_lit("R2", 32'h7, 2);
    cyc("R4", 1'b1, 32'h7, 1'b1, 1'b0);
    expect_lit("R2", 32'h7, 3);

    // R4 / R7 / R9: climb into reuse and saturate at the top
    for (int k = 0; k < 140; k++) cyc("R9", 1'b1, 32'h100, 1'b1, k[0]);
    expect_lit("R7", 32'h100, 4);
    // R5 / R7: fall with big steps from reuse, then unit steps, to the floor
    for (int k = 0; k < 300; k++) cyc("R5", 1'b1, 32'h100, 1'b0, 1'b0);
    expect_lit("R7", 32'h100, 0);
    // R4: big upward steps out of bypass and useless
    for (int k = 0; k < 30; k++) cyc("R4", 1'b1, 32'h100, 1'b1, 1'b1);

    // R6: map hit on miss, and unstrobed cycles, change nothing
    for (int k = 0; k < 10; k++) cyc("R6", 1'b1, 32'h100, 1'b0, 1'b1);
    for (int k = 0; k < 10; k++) cyc("R6", 1'b0, 32'h100, 1'b1, 1'b0);
    for (int k = 0; k < 10; k++) cyc("R6", 1'b0, 32'h100, 1'b0, 1'b0);
    cyc("R6", 1'b0, 32'h100, 1'b0, 1'b0);

    // R1: upper PC bits alias onto the same entry
    for (int k = 0; k < 70; k++) cyc("R1", 1'b1, 32'hABC0_0005, 1'b1, 1'b0);
    expect_lit("R1", 32'h0000_0005, 3);
    cyc("R1", 1'b0, 32'h5555_5405, 1'b0, 1'b0);

    // R3: mixed traffic over a few entries with random upper bits
    for (int k = 0; k < 6000; k++) begin
      logic [31:0] p;
      p = {$urandom() % 32'h0080_0000, 9'd0} | 32'($urandom() % 6 * 3);
      cyc("R3", ($urandom() % 8) != 0, p, $urandom() % 2 == 0, $urandom() % 3 == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule